// File: doc/BRIEF.md
# Skew Tent State Updater

This block holds one 48-bit chaotic state word and advances it by one iteration of a skew tent map on each enabled clock. Both slopes of the map are built from sums of shifted copies of the operand, so the block needs no divider or multiplier and finishes one iteration per cycle. The breakpoint between the two slopes is a fixed 45 % of full scale. Above the breakpoint the state is first reflected against the all-ones maximum, and then the falling slope is applied to that difference.

A coupled random generator uses two identical instances with different reset seeds. A load strobe replaces the state with a new seed at any time. Arithmetic wraps modulo 2^48, in the same way the real-valued map wraps modulo 1. A state that has fallen to zero would stay at zero, so the block restores the reset seed on the next enabled cycle.

Top module: `skt_state_updater`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` becomes the reset seed, 0x0000_0000_3FFF by default. Reset takes priority over `load` and `en`.
- R2: With `rst` low and `load` high at a rising edge, `state` takes the value of `seed` on that edge, whatever the level of `en`.
- R3: With `rst`, `load` and `en` all low, `state` keeps its value across the edge, and changes on `seed` have no effect.
- R4: On an enabled step from a nonzero state p that is strictly below the threshold T = 126663739519794 (floor of 0.45 × (2^48 − 1)), the next state is 2p + floor(p/4) + floor(p/8) + floor(p/16) + floor(p/32), reduced modulo 2^48.
- R5: On an enabled step from a state p ≥ T, let d = (2^48 − 1) − p. The next state is d + floor(d/2) + floor(d/4) + floor(d/16).
- R6: On an enabled step from a state of zero, the next state is the reset seed, not the map result.
- R7: Sums that exceed 2^48 − 1 wrap and are not clamped. For example, a step from p = T − 1 yields the R4 sum minus 2^48, which is smaller than p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Seed write strobe, overrides enable |
| seed | input | 48 | Value written when `load` is high |
| en | input | 1 | Advance the map by one iteration |
| state | output | 48 | Registered state word |

## Verification
The zero state is the hardest case to reach. A chaotic orbit almost never lands on zero by itself. The stimulus therefore gets there in two ways: by loading zero directly, and by loading the all-ones word, whose reflected difference is zero, so that the falling slope produces zero. The wrap at the top of the rising slope only occurs in a narrow band just under the threshold, so the seeds T − 1 and T are loaded on purpose to straddle the comparison.

// File: rtl/skt_pkg.sv
package skt_pkg;

   // Shift term code: bit 7 = left shift, bits 5:0 = amount
   localparam int SKT_CODE_W = 8;

   typedef enum logic [1:0] {
      SKT_HOLD   = 2'd0,
      SKT_LOAD   = 2'd1,
      SKT_STEP   = 2'd2,
      SKT_RESEED = 2'd3
   } skt_op_e;

   function automatic logic [SKT_CODE_W-1:0] skt_term(input logic left, input int amt);
      logic [SKT_CODE_W-1:0] c;
      c      = '0;
      c[7]   = left;
      c[5:0] = amt[5:0];
      return c;
   endfunction

   function automatic logic [63:0] skt_full(input int w);
      return (64'd1 << w) - 64'd1;
   endfunction

   function automatic logic [63:0] skt_threshold(input int w, input int pct);
      return (skt_full(w) * 64'(pct)) / 64'd100;
   endfunction

endpackage

// File: rtl/skt_shift_sum.sv
module skt_shift_sum
   import skt_pkg::*;
#(
   parameter int                      W        = 48,
   parameter int                      N        = 4,
   parameter logic [N*SKT_CODE_W-1:0] CODES    = '0,
   parameter bit                      ADD_TREE = 1'b1
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] sum
);

   localparam int LVL = $clog2(N);
   localparam int NP  = 1 << LVL;

   if (N < 2) begin : g_bad_n
      $error("skt_shift_sum: N must be at least 2");
   end

   logic [W-1:0] term [N];

   for (genvar i = 0; i < N; i++) begin : g_term
      localparam logic [SKT_CODE_W-1:0] C   = CODES[i*SKT_CODE_W +: SKT_CODE_W];
      localparam int                    AMT = int'(C[5:0]);
      if (AMT >= W) begin : g_bad_amt
         $error("skt_shift_sum: shift amount exceeds width");
      end
      if (C[7]) begin : g_left
         assign term[i] = a << AMT;
      end else begin : g_right
         assign term[i] = a >> AMT;
      end
   end

   if (ADD_TREE) begin : g_tree
      for (genvar l = 0; l <= LVL; l++) begin : g_lvl
         logic [W-1:0] v [NP >> l];
         for (genvar j = 0; j < (NP >> l); j++) begin : g_e
            if (l == 0) begin : g_leaf
               if (j < N) begin : g_used
                  assign v[j] = term[j];
               end else begin : g_pad
                  assign v[j] = '0;
               end
            end else begin : g_add
               assign v[j] = g_lvl[l-1].v[2*j] + g_lvl[l-1].v[2*j+1];
            end
         end
      end
      assign sum = g_lvl[LVL].v[0];
   end else begin : g_chain
      for (genvar i = 0; i < N; i++) begin : g_ch
         logic [W-1:0] acc;
         if (i == 0) begin : g_first
            assign acc = term[0];
         end else begin : g_next
            assign acc = g_ch[i-1].acc + term[i];
         end
      end
      assign sum = g_ch[N-1].acc;
   end

endmodule

// File: rtl/skt_rise_branch.sv
module skt_rise_branch
   import skt_pkg::*;
#(
   parameter int W        = 48,
   parameter bit ADD_TREE = 1'b1
) (
   input  logic [W-1:0] p,
   output logic [W-1:0] q
);

   // x2.46875 = 2 + 1/4 + 1/8 + 1/16 + 1/32
   localparam int                        NT    = 5;
   localparam logic [NT*SKT_CODE_W-1:0] CODES = {
      skt_term(1'b0, 5), skt_term(1'b0, 4), skt_term(1'b0, 3),
      skt_term(1'b0, 2), skt_term(1'b1, 1)
   };

   skt_shift_sum #(
      .W(W), .N(NT), .CODES(CODES), .ADD_TREE(ADD_TREE)
   ) u_sum (
      .a   (p),
      .sum (q)
   );

endmodule

// File: rtl/skt_fall_branch.sv
module skt_fall_branch
   import skt_pkg::*;
#(
   parameter int W        = 48,
   parameter bit ADD_TREE = 1'b1
) (
   input  logic [W-1:0] p,
   output logic [W-1:0] q
);

   // x1.8125 = 1 + 1/2 + 1/4 + 1/16, applied to the reflection
   localparam int                        NT    = 4;
   localparam logic [NT*SKT_CODE_W-1:0] CODES = {
      skt_term(1'b0, 4), skt_term(1'b0, 2),
      skt_term(1'b0, 1), skt_term(1'b0, 0)
   };

   logic [W-1:0] refl;

   // all-ones minus p is a plain inversion
   assign refl = ~p;

   skt_shift_sum #(
      .W(W), .N(NT), .CODES(CODES), .ADD_TREE(ADD_TREE)
   ) u_sum (
      .a   (refl),
      .sum (q)
   );

endmodule

// File: rtl/skt_state_updater.sv
module skt_state_updater
   import skt_pkg::*;
#(
   parameter int           W          = 48,
   parameter logic [W-1:0] RESET_SEED = 'h3FFF,
   parameter int           THR_PCT    = 45,
   parameter bit           ADD_TREE   = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         en,
   output logic [W-1:0] state
);

   localparam logic [63:0]  TH64   = skt_threshold(W, THR_PCT);
   localparam logic [W-1:0] THRESH = TH64[W-1:0];
   localparam logic [W-1:0] FULL   = '1;

   if (W < 8 || W > 56) begin : g_bad_w
      $error("skt_state_updater: W must lie in 8..56");
   end
   if (THR_PCT < 1 || THR_PCT > 99) begin : g_bad_pct
      $error("skt_state_updater: THR_PCT must lie in 1..99");
   end
   if (RESET_SEED == '0) begin : g_bad_seed
      $error("skt_state_updater: RESET_SEED must be nonzero");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] rise_q;
   logic [W-1:0] fall_q;
   logic         is_zero;
   logic         below;
   skt_op_e      op;

   skt_rise_branch #(.W(W), .ADD_TREE(ADD_TREE)) u_rise (
      .p (state_q),
      .q (rise_q)
   );

   skt_fall_branch #(.W(W), .ADD_TREE(ADD_TREE)) u_fall (
      .p (state_q),
      .q (fall_q)
   );

   always_comb begin
      is_zero = (state_q == '0);
      below   = (state_q < THRESH);
      if (load)         op = SKT_LOAD;
      else if (!en)     op = SKT_HOLD;
      else if (is_zero) op = SKT_RESEED;
      else              op = SKT_STEP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RESET_SEED;
      end else begin
         unique case (op)
            SKT_LOAD:   state_q <= seed;
            SKT_RESEED: state_q <= RESET_SEED;
            SKT_STEP:   state_q <= below ? rise_q : fall_q;
            default:    state_q <= state_q;
         endcase
      end
   end

   assign state = state_q;

   AST_RESET_SEED: assert property (@(posedge clk)
      rst |=> state == RESET_SEED); // R1

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      load |=> state == $past(seed)); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && !en) |=> $stable(state)); // R3

   AST_RISE_GROWS: assert property (@(posedge clk) disable iff (rst)
      (en && !load && state != '0 && state < (THRESH >> 1)) |=> state > $past(state)); // R4

   AST_FALL_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (en && !load && state >= THRESH) |=> state >= ($past(state) ^ FULL)); // R5

   AST_ZERO_RESEED: assert property (@(posedge clk) disable iff (rst)
      (en && !load && state == '0) |=> state == RESET_SEED); // R6

endmodule

// File: tb/skt_state_updater_test.sv
module skt_state_updater_test;

   localparam int           W        = 48;
   localparam logic [W-1:0] FULL     = '1;
   localparam logic [W-1:0] DEF_SEED = 48'h3FFF;
   localparam logic [W-1:0] TH       = 48'd126663739519794;
   localparam int           NSEEDS   = 8;
   localparam int           NSTEPS   = 10;

   localparam logic [W-1:0] SEEDS [NSEEDS] = '{
      48'h0000_0000_3FFF, 48'h0000_0000_F3FF, 48'h0000_0000_0001,
      48'h0123_4567_89AB, 48'h7FFF_FFFF_FFFF, 48'hA5A5_5A5A_C3C3,
      48'hFFFF_FFFF_FFFE, 48'h5555_5555_5555
   };

   logic         clk  = 1'b0;
   logic         rst  = 1'b1;
   logic         load = 1'b0;
   logic         en   = 1'b0;
   logic [W-1:0] seed = '0;
   logic [W-1:0] state;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   skt_state_updater uut (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .seed  (seed),
      .en    (en),
      .state (state)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] p);
      logic [W-1:0] d;
      if (p == '0) return DEF_SEED;                                        // R6
      if (p < TH) return p * 48'd2 + p / 4 + p / 8 + p / 16 + p / 32;     // R4, R7
      d = FULL - p;                                                        // R5
      return d + d / 2 + d / 4 + d / 16;
   endfunction

   function automatic string tag_of(input logic [W-1:0] p);
      if (p == '0) return "R6";
      if (p < TH) return "R4";
      return "R5";
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_seed(input logic [W-1:0] s, input logic with_en);
      load = 1'b1; seed = s; en = with_en;
      tick;
      load = 1'b0; en = 1'b0;
      chk("R2 load", state, s);
   endtask

   task automatic step_chk(input string tag);
      logic [W-1:0] exp;
      exp = model(state);
      en = 1'b1;
      tick;
      en = 1'b0;
      chk(tag, state, exp);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      tick;
      chk("R1 reset value", state, DEF_SEED);
      rst = 1'b0;

      // R3: idle keeps state while seed toggles
      seed = 48'hDEAD_BEEF_0000;
      tick;
      seed = 48'h1234;
      tick;
      chk("R3 idle hold", state, DEF_SEED);

      // vector table walk: load each seed, then iterate
      for (int i = 0; i < NSEEDS; i++) begin
         load_seed(SEEDS[i], 1'b0);
         for (int k = 0; k < NSTEPS; k++) begin
            step_chk(tag_of(state));
         end
      end

      // R2: load overrides en
      load_seed(48'h0BAD_CAFE_0001, 1'b1);

      // R3: idle after a step sequence
      step_chk("R4 step");
      begin
         logic [W-1:0] held;
         held = state;
         seed = 48'hFFFF_0000_FFFF;
         repeat (3) tick;
         chk("R3 hold after step", state, held);
      end

      // R7: just under threshold wraps
      load_seed(TH - 48'd1, 1'b0);
      begin
         logic [63:0] wide;
         logic [63:0] p64;
         p64  = {16'd0, TH - 48'd1};
         wide = p64 * 2 + p64 / 4 + p64 / 8 + p64 / 16 + p64 / 32 - (64'd1 << 48);
         en = 1'b1;
         tick;
         en = 1'b0;
         chk("R7 wrap below threshold", state, wide[W-1:0]);
      end

      // R5: exactly at threshold takes the falling slope
      load_seed(TH, 1'b0);
      step_chk("R5 at threshold");

      // R6: zero loaded directly
      load_seed('0, 1'b0);
      step_chk("R6 zero reseed");
      chk("R6 zero reseed value", state, DEF_SEED);

      // R5 then R6: all-ones reflects to zero
      load_seed(FULL, 1'b0);
      step_chk("R5 full scale");
      chk("R5 full scale to zero", state, '0);
      step_chk("R6 reseed after full");

      // R1: reset beats load and en mid-run
      en = 1'b1;
      tick;
      rst = 1'b1; load = 1'b1; seed = 48'h7777;
      tick;
      rst = 1'b0; load = 1'b0; en = 1'b0;
      chk("R1 reset priority", state, DEF_SEED);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule